// File: doc/BRIEF.md
# Twin Countdown Timer with Shared Interrupt

This peripheral holds two independent down-counters behind a simple 32-bit register bus. Each counter has its own reload value and control word. The control word has two parts. A two-bit command loads the reload value, freezes the counter or lets it count. A three-bit source code picks which of four external one-cycle tick-enable inputs advances that counter. The tick inputs stand in for clock domains of different rates.

A counter in run mode decrements once per selected tick. On the first selected tick after it reaches zero, it reloads from its reload value and raises an expiry. The period is therefore reload+1 ticks. Each expiry sets a pending bit in a shared status register: timer 0 sets bit 0 and timer 1 sets bit 1. The single interrupt output is high whenever a pending bit is also enabled in the mask register. Software clears pending bits by writing ones to the acknowledge register. A free-running cycle counter can also be read.

Bus writes take effect on the clock edge where `bus_we` is high. Reads are combinational from `bus_addr`.

Top module: `twin_countdown_timer`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) both counters and reload values read 0. Both control words read 1 (hold, source 0). Status and mask read 0, and irq is low.
- R2: Writing a control word whose bits [1:0] are 0 (load) copies that timer's reload value into its counter at that edge. The counter then stays at that value.
- R3: While a timer's command is 1 (hold) or 3 (reserved, treated as hold), its counter does not change.
- R4: With command 2 (run), each selected tick decrements a non-zero counter by one. A selected tick at zero reloads the reload value and counts as one expiry. No counting happens in the cycle the control word is written.
- R5: An expiry of timer 0 sets status bit 0, and an expiry of timer 1 sets status bit 1. The bits stay set until acknowledged.
- R6: Writing the acknowledge register (0x4C) clears each status bit whose written bit is 1 and leaves bits written 0 unchanged. An expiry in the same cycle wins over the clear.
- R7: irq is high exactly when status AND mask (mask at 0x48, bits [1:0]) is non-zero. It follows a mask write on the next cycle.
- R8: Control bits [4:2] select the tick source: codes 4, 5, 6 and 7 use tick_src[0], [1], [2] and [3]. Codes 0 to 3 are illegal, and a running timer with an illegal code never counts.
- R9: Register map: timer n (n = 0, 1) has reload at 0x10·n, counter at 0x10·n+4 and control at 0x10·n+8 (so timer 1 control is 0x18). Status is at 0x50. The acknowledge register and all unmapped offsets read 0.
- R10: Offset 0x38 reads a 32-bit counter that is 0 after reset and increases by one every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_src | input | 4 | One-cycle tick enables for source codes 4 to 7 |
| irq | output | 1 | Masked interrupt request |

## Verification
Assertions check these properties on every cycle:
- a held or illegally sourced counter stays frozen;
- a load write lands the reload value;
- an expiry reloads the counter and sets its pending bit;
- an acknowledge clears the bits it names;
- irq stays up while nothing acknowledges or remasks;
- the time counter steps by one.

Some behaviours only the bench scenarios can show. These are the period of reload+1 ticks under ticks of different rates, the independence of the two timers, the reset values seen at the bus, and the zero reads of unmapped offsets. The bench compares irq against its reference model on every clock and compares register reads against the model at points across the scenarios.

// File: rtl/tmr_pkg.sv
// Package: shared types and offsets of the twin countdown timer.
// Assumes an 8-bit byte-offset bus and at most four tick sources.
package tmr_pkg;

    typedef enum logic [1:0] {
        CMD_LOAD = 2'd0,
        CMD_HOLD = 2'd1,
        CMD_RUN  = 2'd2,
        CMD_RSVD = 2'd3
    } tmr_cmd_e;

    typedef struct packed {
        logic [2:0] sel;
        tmr_cmd_e   cmd;
    } tmr_ctrl_t;

    localparam int CTRL_W   = $bits(tmr_ctrl_t);
    localparam int SRC_BASE = 4;     // lowest legal source code
    localparam int TMR_STEP = 16;    // offset stride between timers

    localparam logic [7:0] OFF_RELOAD = 8'h00;
    localparam logic [7:0] OFF_COUNT  = 8'h04;
    localparam logic [7:0] OFF_CTRL   = 8'h08;
    localparam logic [7:0] OFF_TIME   = 8'h38;
    localparam logic [7:0] OFF_MASK   = 8'h48;
    localparam logic [7:0] OFF_ACK    = 8'h4C;
    localparam logic [7:0] OFF_STATUS = 8'h50;

endpackage

// File: rtl/tmr_channel.sv
// Module: one down-counting timer with reload value, command and source select.
// Assumes write strobes are single-cycle and never hit reload and control together.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NSRC  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload_we,
    input  logic [CNT_W-1:0] reload_wdata,
    input  logic             ctrl_we,
    input  tmr_ctrl_t        ctrl_wdata,
    input  logic [NSRC-1:0]  tick_src,
    output logic [CNT_W-1:0] reload_o,
    output logic [CNT_W-1:0] count_o,
    output tmr_ctrl_t        ctrl_o,
    output logic             expire_o
);

    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] count_q;
    tmr_ctrl_t        ctrl_q;
    logic             tick_sel;
    logic             step;

    // Pick the tick enable named by the source code; illegal codes give none.
    always_comb begin
        tick_sel = 1'b0;
        for (int k = 0; k < NSRC; k++) begin
            if (int'(ctrl_q.sel) == SRC_BASE + k) tick_sel = tick_src[k];
        end
    end

    // A counting step happens on a selected tick in run mode, never during a control write.
    always_comb begin
        step     = !ctrl_we && (ctrl_q.cmd == CMD_RUN) && tick_sel;
        expire_o = step && (count_q == '0);
    end

    // Reload value register.
    always_ff @(posedge clk) begin
        if (!rst_n)         reload_q <= '0;
        else if (reload_we) reload_q <= reload_wdata;
    end

    // Control word register; reset leaves the timer on hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '{sel: 3'd0, cmd: CMD_HOLD};
        else if (ctrl_we) ctrl_q <= ctrl_wdata;
    end

    // Counter: load on a load command, otherwise decrement or reload on a step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (ctrl_we && ctrl_wdata.cmd == CMD_LOAD)
            count_q <= reload_q;
        else if (step)
            count_q <= (count_q == '0) ? reload_q : count_q - 1'b1;
    end

    assign reload_o = reload_q;
    assign count_o  = count_q;
    assign ctrl_o   = ctrl_q;

    a_r3_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_we && ctrl_q.cmd != CMD_RUN) |=> $stable(count_q));

    a_r2_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && ctrl_wdata.cmd == CMD_LOAD) |=> count_q == $past(reload_q));

    a_r4_expiry_reloads: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> count_q == $past(reload_q));

    a_r8_illegal_source_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_we && int'(ctrl_q.sel) < SRC_BASE) |=> $stable(count_q));

endmodule

// File: rtl/tmr_irq_ctrl.sv
// Module: shared pending-status, mask and acknowledge logic driving one interrupt.
// Assumes expiry inputs are single-cycle pulses, one bit per timer.
module tmr_irq_ctrl #(
    parameter int NT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mask_we,
    input  logic          ack_we,
    input  logic [NT-1:0] wbits,
    input  logic [NT-1:0] expire,
    output logic [NT-1:0] status_o,
    output logic [NT-1:0] mask_o,
    output logic          irq_o
);

    logic [NT-1:0] status_q;
    logic [NT-1:0] mask_q;
    logic [NT-1:0] clr;

    // Bits named by an acknowledge write.
    always_comb clr = ack_we ? wbits : '0;

    // Pending bits: write-one-to-clear, with a new expiry winning.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr) | expire;
    end

    // Mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)      mask_q <= '0;
        else if (mask_we) mask_q <= wbits;
    end

    // Interrupt when any enabled bit is pending.
    always_comb irq_o = |(status_q & mask_q);

    assign status_o = status_q;
    assign mask_o   = mask_q;

    a_r5_pending_set: assert property (@(posedge clk) disable iff (!rst_n)
        (|expire) |=> ((status_q & $past(expire)) == $past(expire)));

    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && expire == '0) |=> ((status_q & $past(wbits)) == '0));

    a_r7_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_we && !mask_we) |=> irq_o);

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (status_q == '0 && mask_q == '0 && !irq_o));

endmodule

// File: rtl/tmr_regs.sv
// Module: address decode, read-back multiplexer and free-running time counter.
// Assumes word-aligned byte offsets; unmapped reads return zero.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NT    = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_we,
    input  logic [7:0]                bus_addr,
    input  logic [31:0]               bus_wdata,
    input  logic [NT-1:0][CNT_W-1:0]  reload_i,
    input  logic [NT-1:0][CNT_W-1:0]  count_i,
    input  logic [NT-1:0][CTRL_W-1:0] ctrl_i,
    input  logic [NT-1:0]             status_i,
    input  logic [NT-1:0]             mask_i,
    output logic [NT-1:0]             reload_we,
    output logic [NT-1:0]             ctrl_we,
    output logic                      mask_we,
    output logic                      ack_we,
    output logic [31:0]               bus_rdata
);

    logic [31:0] time_q;
    logic        wdata_unused;

    assign wdata_unused = ^bus_wdata[31:CNT_W];

    // Write strobes per register.
    always_comb begin
        for (int i = 0; i < NT; i++) begin
            reload_we[i] = bus_we && (bus_addr == 8'(i * TMR_STEP) + OFF_RELOAD);
            ctrl_we[i]   = bus_we && (bus_addr == 8'(i * TMR_STEP) + OFF_CTRL);
        end
        mask_we = bus_we && (bus_addr == OFF_MASK);
        ack_we  = bus_we && (bus_addr == OFF_ACK);
    end

    // Read-back multiplexer.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NT; i++) begin
            if (bus_addr == 8'(i * TMR_STEP) + OFF_RELOAD) bus_rdata = 32'(reload_i[i]);
            if (bus_addr == 8'(i * TMR_STEP) + OFF_COUNT)  bus_rdata = 32'(count_i[i]);
            if (bus_addr == 8'(i * TMR_STEP) + OFF_CTRL)   bus_rdata = 32'(ctrl_i[i]);
        end
        if (bus_addr == OFF_TIME)   bus_rdata = time_q;
        if (bus_addr == OFF_MASK)   bus_rdata = 32'(mask_i);
        if (bus_addr == OFF_STATUS) bus_rdata = 32'(status_i);
    end

    // Free-running cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) time_q <= '0;
        else        time_q <= time_q + 32'd1;
    end

    a_r10_time_steps: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> time_q == $past(time_q) + 32'd1);

    a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reload_we, ctrl_we, mask_we, ack_we}));

endmodule

// File: rtl/twin_countdown_timer.sv
// Module: top of the twin countdown timer: two channels, register block, interrupt logic.
// Assumes NSRC <= 4 so that every source code fits in three bits.
module twin_countdown_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NSRC  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_we,
    input  logic [7:0]      bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    input  logic [NSRC-1:0] tick_src,
    output logic            irq
);

    localparam int NT = 2;

    logic [NT-1:0][CNT_W-1:0]  reload_v;
    logic [NT-1:0][CNT_W-1:0]  count_v;
    logic [NT-1:0][CTRL_W-1:0] ctrl_v;
    logic [NT-1:0]             reload_we;
    logic [NT-1:0]             ctrl_we;
    logic [NT-1:0]             expire;
    logic [NT-1:0]             status;
    logic [NT-1:0]             mask;
    logic                      mask_we;
    logic                      ack_we;

    tmr_regs #(.CNT_W(CNT_W), .NT(NT)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .reload_i  (reload_v),
        .count_i   (count_v),
        .ctrl_i    (ctrl_v),
        .status_i  (status),
        .mask_i    (mask),
        .reload_we (reload_we),
        .ctrl_we   (ctrl_we),
        .mask_we   (mask_we),
        .ack_we    (ack_we),
        .bus_rdata (bus_rdata)
    );

    for (genvar g = 0; g < NT; g++) begin : g_chan
        tmr_ctrl_t ctrl_q;
        tmr_channel #(.CNT_W(CNT_W), .NSRC(NSRC)) u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .reload_we    (reload_we[g]),
            .reload_wdata (bus_wdata[CNT_W-1:0]),
            .ctrl_we      (ctrl_we[g]),
            .ctrl_wdata   (tmr_ctrl_t'(bus_wdata[CTRL_W-1:0])),
            .tick_src     (tick_src),
            .reload_o     (reload_v[g]),
            .count_o      (count_v[g]),
            .ctrl_o       (ctrl_q),
            .expire_o     (expire[g])
        );
        assign ctrl_v[g] = ctrl_q;
    end

    tmr_irq_ctrl #(.NT(NT)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mask_we  (mask_we),
        .ack_we   (ack_we),
        .wbits    (bus_wdata[NT-1:0]),
        .expire   (expire),
        .status_o (status),
        .mask_o   (mask),
        .irq_o    (irq)
    );

endmodule

// File: tb/tb_twin_countdown_timer.sv
module tb_twin_countdown_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [3:0]  tick_src = 4'h0;
    logic        irq;

    int  checks = 0;
    int  fails = 0;
    bit  ended = 0;
    bit  t3en = 0;
    int  cyc = 0;

    // behavioural reference model state
    int          m_div [2];
    int          m_cnt [2];
    int          m_cmd [2];
    int          m_sel [2];
    int          m_status, m_mask;
    int unsigned m_time;

    twin_countdown_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_src(tick_src), .irq(irq)
    );

    always #10 clk = ~clk;

    // tick pattern: src0 every cycle, src1 every 3rd, src2 every 7th, src3 on demand
    always @(negedge clk) begin
        cyc = cyc + 1;
        tick_src = {t3en, (cyc % 7) == 0, (cyc % 3) == 0, 1'b1};
    end

    // reference model advanced on every rising edge
    always @(posedge clk) begin
        int fire;
        fire = 0;
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_div[i] = 0; m_cnt[i] = 0; m_cmd[i] = 1; m_sel[i] = 0;
            end
            m_status = 0; m_mask = 0; m_time = 0;
        end else begin
            for (int i = 0; i < 2; i++) begin
                if (bus_we && bus_addr == 8'(i * 16 + 8)) begin
                    m_cmd[i] = int'(bus_wdata[1:0]);
                    m_sel[i] = int'(bus_wdata[4:2]);
                    if (m_cmd[i] == 0) m_cnt[i] = m_div[i];
                end else if (m_cmd[i] == 2 && m_sel[i] >= 4 && tick_src[m_sel[i] - 4]) begin
                    if (m_cnt[i] == 0) begin
                        m_cnt[i] = m_div[i];
                        fire = fire | (1 << i);
                    end else begin
                        m_cnt[i] = m_cnt[i] - 1;
                    end
                end
                if (bus_we && bus_addr == 8'(i * 16)) m_div[i] = int'(bus_wdata[15:0]);
            end
            if (bus_we && bus_addr == 8'h4C) m_status = m_status & ~int'(bus_wdata[1:0]);
            m_status = m_status | fire;
            if (bus_we && bus_addr == 8'h48) m_mask = int'(bus_wdata[1:0]);
            m_time = m_time + 1;
        end
    end

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h00: return 32'(m_div[0]);
            8'h04: return 32'(m_cnt[0]);
            8'h08: return 32'((m_sel[0] << 2) | m_cmd[0]);
            8'h10: return 32'(m_div[1]);
            8'h14: return 32'(m_cnt[1]);
            8'h18: return 32'((m_sel[1] << 2) | m_cmd[1]);
            8'h38: return m_time;
            8'h48: return 32'(m_mask);
            8'h50: return 32'(m_status);
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // irq compared with the model on every clock (R7)
    always @(negedge clk) begin
        if (rst_n && !ended) chk(irq == ((m_status & m_mask) != 0), "R7 irq", 32'(irq),
                                 32'((m_status & m_mask) != 0));
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag, output logic [31:0] v);
        logic [31:0] e;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #2;
        v = bus_rdata;
        e = model_read(a);
        chk(v == e, tag, v, e);
    endtask

    task automatic finish_up;
        ended = 1;
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_up();
    end

    initial begin
        logic [31:0] v, v0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(8'h08, "R1 ctrl0", v); chk(v == 32'h1, "R1 ctrl0 hold", v, 32'h1);
        rd(8'h18, "R1 ctrl1", v); chk(v == 32'h1, "R1 ctrl1 hold", v, 32'h1);
        rd(8'h04, "R1 count0", v);
        rd(8'h50, "R1 status", v); chk(v == 0, "R1 status zero", v, 0);
        rd(8'h48, "R1 mask", v);
        chk(irq == 1'b0, "R1 irq low", 32'(irq), 0);

        // R2 load, R4 run on source 4 (tick_src[0])
        wr(8'h00, 32'd5);
        wr(8'h08, 32'((4 << 2) | 0));
        rd(8'h04, "R2 load count0", v); chk(v == 32'd5, "R2 loaded value", v, 32'd5);
        wr(8'h08, 32'((4 << 2) | 2));
        repeat (3) @(negedge clk);
        rd(8'h04, "R4 count0 running", v);
        repeat (9) @(negedge clk);
        rd(8'h50, "R5 status bit0", v); chk(v[0] == 1'b1, "R5 timer0 pending", v, 32'h1);
        rd(8'h04, "R4 count0 after wrap", v);

        // R7 unmasking raises irq
        wr(8'h48, 32'h1);
        @(negedge clk); chk(irq == 1'b1, "R7 irq after mask", 32'(irq), 1);

        // R6 ack writing zero has no effect
        wr(8'h4C, 32'h0);
        rd(8'h50, "R6 ack zero", v);

        // R3 hold freezes
        wr(8'h08, 32'((4 << 2) | 1));
        rd(8'h04, "R3 count0 hold", v0);
        repeat (5) @(negedge clk);
        rd(8'h04, "R3 count0 still", v); chk(v == v0, "R3 hold stable", v, v0);

        // R6 ack clears
        wr(8'h4C, 32'h1);
        rd(8'h50, "R6 ack one", v); chk(v[0] == 1'b0, "R6 bit0 cleared", v, 0);
        chk(irq == 1'b0, "R7 irq after ack", 32'(irq), 0);

        // R5 timer1 on source 5 (tick_src[1]), masked off
        wr(8'h10, 32'd3);
        wr(8'h18, 32'((5 << 2) | 0));
        wr(8'h18, 32'((5 << 2) | 2));
        repeat (20) @(negedge clk);
        rd(8'h14, "R4 count1", v);
        rd(8'h50, "R5 status bit1", v); chk(v[1] == 1'b1, "R5 timer1 pending", v, 32'h2);
        chk(irq == 1'b0, "R7 masked bit1", 32'(irq), 0);
        wr(8'h48, 32'h2);
        @(negedge clk); chk(irq == 1'b1, "R7 irq bit1", 32'(irq), 1);
        wr(8'h4C, 32'h2);
        wr(8'h18, 32'((5 << 2) | 1));

        // R8 illegal source code 2 never counts
        wr(8'h08, 32'((2 << 2) | 2));
        rd(8'h04, "R8 count0 illegal", v0);
        repeat (8) @(negedge clk);
        rd(8'h04, "R8 count0 illegal still", v); chk(v == v0, "R8 illegal frozen", v, v0);

        // R8 source 7 follows tick_src[3]
        wr(8'h08, 32'((7 << 2) | 2));
        rd(8'h04, "R8 src7 idle", v0);
        repeat (4) @(negedge clk);
        rd(8'h04, "R8 src7 no tick", v); chk(v == v0, "R8 src7 without tick", v, v0);
        t3en = 1;
        repeat (3) @(negedge clk);
        t3en = 0;
        rd(8'h04, "R8 src7 ticking", v);

        // R3 reserved command 3 acts as hold
        wr(8'h08, 32'((4 << 2) | 3));
        rd(8'h04, "R3 rsvd", v0);
        repeat (4) @(negedge clk);
        rd(8'h04, "R3 rsvd still", v); chk(v == v0, "R3 rsvd frozen", v, v0);

        // R9 unmapped and ack read zero
        rd(8'h0C, "R9 unmapped 0C", v); chk(v == 0, "R9 0C zero", v, 0);
        rd(8'h20, "R9 unmapped 20", v);
        rd(8'h4C, "R9 ack reads 0", v); chk(v == 0, "R9 ack zero", v, 0);
        rd(8'hFC, "R9 unmapped FC", v);

        // R10 time counter
        rd(8'h38, "R10 time a", v0);
        repeat (4) @(negedge clk);
        rd(8'h38, "R10 time b", v); chk(v - v0 == 32'd5, "R10 time delta", v - v0, 32'd5);

        // R1 reset in the middle of a run
        wr(8'h08, 32'((4 << 2) | 2));
        wr(8'h48, 32'h3);
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(8'h08, "R1 ctrl0 after reset", v); chk(v == 32'h1, "R1 ctrl0 reset", v, 32'h1);
        rd(8'h04, "R1 count0 after reset", v);
        rd(8'h50, "R1 status after reset", v); chk(v == 0, "R1 status reset", v, 0);
        chk(irq == 1'b0, "R1 irq after reset", 32'(irq), 0);

        repeat (3) @(negedge clk);
        finish_up();
    end

endmodule